// File: doc/BRIEF.md
# Internal Clock Source Selector

This block picks the system clock from two on-chip references. One is a fast reference. The other is a slow, low-power reference. The fast reference drives a binary postscaler. The postscaler offers seven ratios, from the undivided reference down to a divide-by-64 tap, plus a divide-by-256 tap for the lowest setting. A 3-bit frequency code selects the ratio. At the lowest code, a source-select bit in the tuning register decides between two sources: the divide-by-256 tap or the slow reference. Changing the selection hands the output over without glitches. The old source is released on its own falling edge. The new source is gated in on its own falling edge, and only after the old one has let go.

The block also drives two oscillator enables. It raises the slow-reference enable whenever any supervisory feature asks for that reference, and it keeps each enable up until the handover away from that reference is complete. The tuning register carries a trim code and a PLL request. The trim code goes out to the analog trim circuit. The PLL request is passed on only while a fast-derived source is selected. A registered divide-by-four of the system clock feeds one oscillator pin. In the other pin mode, that pin becomes general I/O and the divided clock is held low.

Register writes are single-cycle strobes sampled on the fast reference's rising edge. They have no handshake and no back-pressure, because the block has no data stream. All other pins are plain levels.

Top module: `int_clk_sel`

## Requirements
- R1: After reset the trim code is 0, the PLL request is 0, the frequency code is 000 and the source-select bit is 0. As a result, `sys_clk` follows the slow reference, `fast_en` is 0 and `slow_en` is 1.
- R2: A frequency code c from 001 to 111 makes `sys_clk` the fast reference divided by 2^(7-c): 111 passes it undivided, and 001 divides it by 64.
- R3: With code 000, tuning bit 7 set makes `sys_clk` the fast reference divided by 256. Tuning bit 7 clear makes `sys_clk` the slow reference.
- R4: `fast_en` is 1 whenever a fast-derived source is selected, that is when the code is not 000 or tuning bit 7 is set. Once a handover to the slow reference has finished, `fast_en` is 0.
- R5: `slow_en` is 1 while the slow reference is selected or still gated. It is also 1 whenever any `sup_req` bit is set: bit 0 is the power-up timer, bit 1 the fail-safe monitor, bit 2 the watchdog and bit 3 the two-speed start-up.
- R6: A tuning write stores `wr_data[4:0]` as the trim code on `trim`. The trim code has no effect on which clock is selected or on its period, and this includes the slow reference.
- R7: `pll_req` equals tuning bit 6 while a fast-derived source is selected, and is 0 otherwise.
- R8: At most one source is gated onto `sys_clk` at any time. No high or low pulse of `sys_clk` is shorter than half a fast-reference period.
- R9: With `pin_io_mode` = 0, `clk_div4_out` runs at `sys_clk`/4, `pin_b_clk_en` = 1 and `pin_b_gpio_en` = 0.
- R10: With `pin_io_mode` = 1, `clk_div4_out` is held low, `pin_b_gpio_en` = 1 and `pin_b_clk_en` = 0. `pin_a_gpio_en` is 1 in both modes.
- R11: A frequency write stores only `wr_data[2:0]` and ignores the upper bits. Writes of either register take effect on the fast-reference rising edge on which their strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast reference clock; also the register clock |
| slow_clk | input | 1 | Slow low-power reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_we | input | 1 | Tuning register write strobe |
| fsel_we | input | 1 | Frequency code write strobe |
| wr_data | input | 8 | Write data for either register |
| sup_req | input | 4 | Supervisory requests for the slow reference |
| pin_io_mode | input | 1 | 0: pin B drives clock-out; 1: both pins are I/O |
| sys_clk | output | 1 | Selected system clock |
| fast_en | output | 1 | Fast reference enable |
| slow_en | output | 1 | Slow reference enable |
| pll_req | output | 1 | PLL enable toward the loop |
| trim | output | 5 | Trim code toward the analog trim circuit |
| clk_div4_out | output | 1 | System clock divided by four |
| pin_b_clk_en | output | 1 | Pin B carries the divided clock |
| pin_b_gpio_en | output | 1 | Pin B acts as general I/O |
| pin_a_gpio_en | output | 1 | Pin A acts as general I/O |

## Verification
The bench measures the `sys_clk` period after every selection in its table.

- The lowest code is run with both values of the source-select bit. A decoder that ignored the bit would give a 1000 ns period where 1280 ns is expected, or the reverse.
- A frequency write with junk in its upper bits catches a decoder that uses too many bits.
- A trim write while the slow reference is selected catches trim leaking into the slow path.
- A PLL request set while the slow reference is selected catches a PLL request that is not gated by the source.
- A monitor records the shortest high and low pulse on `sys_clk` over every switch in the run. A handover that gated on the wrong edge, or let two sources overlap, would show up as a sliver pulse.

// File: rtl/icsel_pkg.sv
`timescale 1ns/100ps
package icsel_pkg;
  localparam int FSEL_W     = 3;
  localparam int TRIM_W     = 5;
  localparam int SUP_W      = 4;
  localparam int WR_W       = 8;
  localparam int ALT_BIT    = 7;  // source select for the lowest code
  localparam int PLL_BIT    = 6;
  localparam int DIV_STAGES = 2 ** FSEL_W;           // deepest tap divides by 2**DIV_STAGES
  localparam int NSRC       = DIV_STAGES + 2;        // taps 0..DIV_STAGES plus slow reference
  localparam int SLOW_IDX   = NSRC - 1;
  localparam int SRC_W      = $clog2(NSRC);

  typedef struct packed {
    logic              alt_src;
    logic              pll_on;
    logic [TRIM_W-1:0] trim;
  } tune_t;

  // Source index: tap j carries fast/2**j, index SLOW_IDX is the slow reference
  function automatic logic [SRC_W-1:0] src_index(input logic [FSEL_W-1:0] code,
                                                 input logic alt);
    if (code != '0) return SRC_W'((2 ** FSEL_W - 1) - int'(code));
    else if (alt)   return SRC_W'(DIV_STAGES);
    else            return SRC_W'(SLOW_IDX);
  endfunction
endpackage

// File: rtl/icsel_regs.sv
`timescale 1ns/100ps
module icsel_regs
  import icsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tune_we,
  input  logic              fsel_we,
  input  logic [WR_W-1:0]   wr_data,
  output tune_t             tune_q,
  output logic [FSEL_W-1:0] fsel_q,
  output logic [NSRC-1:0]   sel_oh,
  output logic              want_fast,
  output logic              pll_req
);
  logic [SRC_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_q <= '0;
      fsel_q <= '0;
    end else begin
      if (tune_we) begin
        tune_q.alt_src <= wr_data[ALT_BIT];
        tune_q.pll_on  <= wr_data[PLL_BIT];
        tune_q.trim    <= wr_data[TRIM_W-1:0];
      end
      if (fsel_we) fsel_q <= wr_data[FSEL_W-1:0];
    end
  end

  assign idx = src_index(fsel_q, tune_q.alt_src);

  always_comb begin
    for (int k = 0; k < NSRC; k++) sel_oh[k] = (idx == SRC_W'(k));
  end

  assign want_fast = (idx != SRC_W'(SLOW_IDX));
  assign pll_req   = tune_q.pll_on & want_fast;

  AST_FAST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fsel_we && (wr_data[FSEL_W-1:0] != '0) |=> want_fast);  // R4
  AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tune_we |=> $stable(tune_q.trim));  // R6
  AST_PLL_OFF_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fsel_we && !tune_we && (wr_data[FSEL_W-1:0] == '0) && !tune_q.alt_src |=> !pll_req);  // R7
endmodule

// File: rtl/icsel_postscale.sv
`timescale 1ns/100ps
module icsel_postscale #(
  parameter int STAGES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [STAGES:0] taps
);
  logic [STAGES-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // tap j toggles at fast/2**j
  assign taps = {cnt, clk};
endmodule

// File: rtl/icsel_gf_mux.sv
`timescale 1ns/100ps
module icsel_gf_mux #(
  parameter int N = 10
) (
  input  logic [N-1:0] src_clk,
  input  logic [N-1:0] sel_oh,
  input  logic         rst_n,
  input  logic         mon_clk,
  output logic         clk_out,
  output logic [N-1:0] en_q
);
  logic [N-1:0] s1v;
  logic [N-1:0] s2v;

  for (genvar g = 0; g < N; g++) begin : g_src
    localparam logic [N-1:0] OTHERS = ~({{(N-1){1'b0}}, 1'b1} << g);
    logic ck;
    logic busy;
    logic s1;
    logic s2;
    assign ck   = src_clk[g];
    // another branch is arming or gated: hold off
    assign busy = |((s1v | s2v) & OTHERS);
    always_ff @(negedge ck or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= sel_oh[g] & ~busy;
        s2 <= s1;
      end
    end
    assign s1v[g] = s1;
    assign s2v[g] = s2;
  end

  assign en_q    = s2v;
  assign clk_out = |(src_clk & en_q);

  AST_ONE_SOURCE: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $onehot0(en_q));  // R8
endmodule

// File: rtl/icsel_div4.sv
`timescale 1ns/100ps
module icsel_div4 #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic io_mode,
  output logic clk_q
);
  logic [DIV_LOG2-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (io_mode) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign clk_q = cnt[DIV_LOG2-1];

  AST_CLKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    io_mode |=> !clk_q);  // R10
endmodule

// File: rtl/int_clk_sel.sv
`timescale 1ns/100ps
module int_clk_sel
  import icsel_pkg::*;
(
  input  logic              fast_clk,
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              tune_we,
  input  logic              fsel_we,
  input  logic [WR_W-1:0]   wr_data,
  input  logic [SUP_W-1:0]  sup_req,
  input  logic              pin_io_mode,
  output logic              sys_clk,
  output logic              fast_en,
  output logic              slow_en,
  output logic              pll_req,
  output logic [TRIM_W-1:0] trim,
  output logic              clk_div4_out,
  output logic              pin_b_clk_en,
  output logic              pin_b_gpio_en,
  output logic              pin_a_gpio_en
);
  tune_t               tune_q;
  logic [FSEL_W-1:0]   fsel_q;
  logic [NSRC-1:0]     sel_oh;
  logic                want_fast;
  logic [DIV_STAGES:0] taps;
  logic [NSRC-1:0]     en_q;

  icsel_regs u_regs (
    .clk       (fast_clk),
    .rst_n     (rst_n),
    .tune_we   (tune_we),
    .fsel_we   (fsel_we),
    .wr_data   (wr_data),
    .tune_q    (tune_q),
    .fsel_q    (fsel_q),
    .sel_oh    (sel_oh),
    .want_fast (want_fast),
    .pll_req   (pll_req)
  );

  icsel_postscale #(.STAGES(DIV_STAGES)) u_post (
    .clk   (fast_clk),
    .rst_n (rst_n),
    .taps  (taps)
  );

  icsel_gf_mux #(.N(NSRC)) u_mux (
    .src_clk ({slow_clk, taps}),
    .sel_oh  (sel_oh),
    .rst_n   (rst_n),
    .mon_clk (fast_clk),
    .clk_out (sys_clk),
    .en_q    (en_q)
  );

  icsel_div4 #(.DIV_LOG2(2)) u_div4 (
    .clk     (sys_clk),
    .rst_n   (rst_n),
    .io_mode (pin_io_mode),
    .clk_q   (clk_div4_out)
  );

  // keep each reference running until its branch has been released
  assign fast_en = want_fast | (|en_q[DIV_STAGES:0]);
  assign slow_en = sel_oh[SLOW_IDX] | en_q[SLOW_IDX] | (|sup_req);
  assign trim    = tune_q.trim;

  assign pin_b_clk_en  = ~pin_io_mode;
  assign pin_b_gpio_en = pin_io_mode;
  assign pin_a_gpio_en = 1'b1;
endmodule

// File: tb/int_clk_sel_tb_top.sv
`timescale 1ns/100ps
module int_clk_sel_tb_top;
  logic       fast_clk = 1'b0;
  logic       slow_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tune_we = 1'b0;
  logic       fsel_we = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] sup_req = '0;
  logic       pin_io_mode = 1'b0;
  logic       sys_clk, fast_en, slow_en, pll_req, clk_div4_out;
  logic       pin_b_clk_en, pin_b_gpio_en, pin_a_gpio_en;
  logic [4:0] trim;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  int_clk_sel dut_i (
    .fast_clk(fast_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .tune_we(tune_we), .fsel_we(fsel_we), .wr_data(wr_data),
    .sup_req(sup_req), .pin_io_mode(pin_io_mode),
    .sys_clk(sys_clk), .fast_en(fast_en), .slow_en(slow_en),
    .pll_req(pll_req), .trim(trim), .clk_div4_out(clk_div4_out),
    .pin_b_clk_en(pin_b_clk_en), .pin_b_gpio_en(pin_b_gpio_en),
    .pin_a_gpio_en(pin_a_gpio_en)
  );

  always #2.5 fast_clk = ~fast_clk;            // 200 MHz
  initial begin
    #3.7;
    forever #500 slow_clk = ~slow_clk;         // slow reference, 1000 ns
  end

  // shortest pulses seen on sys_clk (R8)
  realtime last_rise = -1.0, last_fall = -1.0, min_hi = 1.0e9, min_lo = 1.0e9;
  always @(posedge sys_clk) begin
    if (last_fall >= 0.0 && ($realtime - last_fall) < min_lo) min_lo = $realtime - last_fall;
    last_rise = $realtime;
  end
  always @(negedge sys_clk) begin
    if (last_rise >= 0.0 && ($realtime - last_rise) < min_hi) min_hi = $realtime - last_rise;
    last_fall = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input bit to_tune, input logic [7:0] d);
    @(negedge fast_clk);
    wr_data = d;
    tune_we = to_tune;
    fsel_we = !to_tune;
    @(negedge fast_clk);
    tune_we = 1'b0;
    fsel_we = 1'b0;
  endtask

  task automatic period_of(input bit of_div4, output int p);
    realtime t1;
    if (of_div4) @(posedge clk_div4_out); else @(posedge sys_clk);
    t1 = $realtime;
    if (of_div4) @(posedge clk_div4_out); else @(posedge sys_clk);
    p = int'($realtime - t1);
  endtask

  // {tuning byte, frequency byte, expected sys_clk period in ns}
  localparam logic [27:0] VEC [12] = '{
    {8'h00, 8'h07, 12'd5},
    {8'h1F, 8'h06, 12'd10},
    {8'h40, 8'h05, 12'd20},
    {8'h00, 8'h04, 12'd40},
    {8'h0A, 8'h03, 12'd80},
    {8'h00, 8'h02, 12'd160},
    {8'h40, 8'h01, 12'd320},
    {8'h55, 8'h00, 12'd1000},  // slow ref, trim and PLL bit set
    {8'hC3, 8'h00, 12'd1280},  // lowest code from fast/256
    {8'h80, 8'hF9, 12'd320},   // upper frequency bits ignored (R11)
    {8'h80, 8'h0F, 12'd5},
    {8'h00, 8'h00, 12'd1000}
  };

  initial begin
    int p;
    bit ok;
    // reset state (R1)
    repeat (5) @(negedge fast_clk);
    check(trim == 5'd0, "R1", "trim in reset", trim, 0);
    check(pll_req == 1'b0, "R1", "pll_req in reset", pll_req, 0);
    check(fast_en == 1'b0, "R1", "fast_en in reset", fast_en, 0);
    check(slow_en == 1'b1, "R1", "slow_en in reset", slow_en, 1);
    check(pin_a_gpio_en == 1'b1, "R10", "pin_a_gpio_en", pin_a_gpio_en, 1);
    rst_n = 1'b1;
    repeat (1000) @(negedge fast_clk);
    period_of(1'b0, p);
    check(p == 1000, "R1", "period after reset", p, 1000);
    @(negedge fast_clk);
    check(fast_en == 1'b0, "R1", "fast_en after reset", fast_en, 0);

    // table walk
    for (int i = 0; i < 12; i++) begin
      logic [7:0] tv;
      logic [7:0] fv;
      int  per;
      bit  exp_fast;
      tv = VEC[i][27:20];
      fv = VEC[i][19:12];
      per = int'(VEC[i][11:0]);
      wr(1'b1, tv);
      wr(1'b0, fv);
      repeat (2000) @(negedge fast_clk);
      exp_fast = (fv[2:0] != 3'b000) || tv[7];
      check(fast_en == exp_fast, "R4", "fast_en", fast_en, exp_fast);
      check(trim == tv[4:0], "R6", "trim", trim, tv[4:0]);
      check(pll_req == (tv[6] && exp_fast), "R7", "pll_req", pll_req, tv[6] && exp_fast);
      period_of(1'b0, p);
      if (i == 9)      check(p == per, "R11", "period, junk upper bits", p, per);
      else if (fv == 0) check(p == per, "R3", "period at lowest code", p, per);
      else              check(p == per, "R2", "period", p, per);
    end

    // clock-out pin mode (R9)
    pin_io_mode = 1'b0;
    wr(1'b0, 8'h07);
    repeat (2000) @(negedge fast_clk);
    period_of(1'b1, p);
    check(p == 20, "R9", "clk_div4 period at 5 ns", p, 20);
    check(pin_b_clk_en == 1'b1, "R9", "pin_b_clk_en", pin_b_clk_en, 1);
    check(pin_b_gpio_en == 1'b0, "R9", "pin_b_gpio_en", pin_b_gpio_en, 0);
    wr(1'b0, 8'h05);
    repeat (2000) @(negedge fast_clk);
    period_of(1'b1, p);
    check(p == 80, "R9", "clk_div4 period at 20 ns", p, 80);

    // I/O pin mode (R10)
    pin_io_mode = 1'b1;
    repeat (10) @(negedge fast_clk);
    ok = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge fast_clk);
      if (clk_div4_out !== 1'b0) ok = 1'b0;
    end
    check(ok, "R10", "clk_div4 held low", clk_div4_out, 0);
    check(pin_b_gpio_en == 1'b1, "R10", "pin_b_gpio_en", pin_b_gpio_en, 1);
    check(pin_b_clk_en == 1'b0, "R10", "pin_b_clk_en", pin_b_clk_en, 0);
    check(pin_a_gpio_en == 1'b1, "R10", "pin_a_gpio_en", pin_a_gpio_en, 1);
    pin_io_mode = 1'b0;

    // supervisory requests (R5), fast source selected
    @(negedge fast_clk);
    check(slow_en == 1'b0, "R5", "slow_en idle", slow_en, 0);
    for (int b = 0; b < 4; b++) begin
      sup_req = 4'(1 << b);
      @(negedge fast_clk);
      check(slow_en == 1'b1, "R5", $sformatf("slow_en for request bit %0d", b), slow_en, 1);
      sup_req = '0;
      @(negedge fast_clk);
      check(slow_en == 1'b0, "R5", "slow_en released", slow_en, 0);
    end

    // glitch-free handover over the whole run (R8), widths in tenths of ns
    check(min_hi >= 2.45, "R8", "shortest high pulse", int'(min_hi * 10.0), 25);
    check(min_lo >= 2.45, "R8", "shortest low pulse", int'(min_lo * 10.0), 25);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge fast_clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule